// File: doc/BRIEF.md
# Instruction Word Decoder with Trailing Immediate

This block sits behind an instruction fetch stream. It accepts 32-bit words over a valid/ready handshake, splits each instruction word into a format code, an 8-bit opcode and 7-bit register or function fields, and hands one decoded record per instruction to the next stage over a second valid/ready handshake. The top two bits of a word choose which fields it carries. The decoder takes one word per cycle while the consumer keeps up.

When bit 0 of a legal instruction word is set, the decoder does not emit that instruction yet. It keeps the decoded fields, enters a waiting state, and treats the next accepted stream word as a 32-bit immediate. The immediate is then delivered together with the instruction fields in a single record. A synchronous flush drops any instruction that is only partly collected and returns the decoder to its idle state. Execution, hazard handling and branch redirection belong to later stages.

Top module: `fetch_word_decoder`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A word with bits 31:30 = 00 decodes with out_fmt = 0, out_opcode = bits 29:22, out_src_b = bits 21:15, out_src_a = bits 14:8, out_dst_a = bits 7:1, and out_dst_b = out_func = 0.
- R3: A word with bits 31:30 = 01 decodes with out_fmt = 1, out_opcode = bits 29:22, out_src_a = bits 21:15, out_dst_b = bits 14:8, out_dst_a = bits 7:1, and out_src_b = out_func = 0.
- R4: A word with bits 31:30 = 10 decodes with out_fmt = 2, out_opcode = bits 29:22, out_func = bits 21:15, out_src_a = bits 14:8, out_dst_a = bits 7:1, and out_src_b = out_dst_b = 0.
- R5: A word with bits 31:30 = 11 yields a record with out_illegal = 1, out_fmt = 3 and opcode, register, function, immediate and out_imm_vld all 0; its bit 0 is ignored, so the next accepted word is decoded as a new instruction.
- R6: A legal word with bit 0 = 1 produces no record on its own; the next accepted word becomes out_imm with out_imm_vld = 1 in the same record, and out_valid stays 0 while the decoder waits for it.
- R7: A legal word with bit 0 = 0 yields out_imm_vld = 0 and out_imm = 0.
- R8: out_valid is 1 in the cycle after the word that completes an instruction (the plain word, the illegal word, or the trailer) is accepted, and records leave in stream order.
- R9: While out_valid = 1 and out_ready = 0, the record on the outputs stays unchanged and in_ready is 0; otherwise, without flush, in_ready is 1.
- R10: With flush = 1, in_ready is 0, the next cycle shows out_valid = 0, and any instruction waiting for its trailer is discarded so the next accepted word decodes as an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous discard of held and partial instructions |
| in_valid | input | 1 | Stream word present |
| in_ready | output | 1 | Decoder takes the stream word this cycle |
| in_word | input | 32 | Stream word: instruction or trailing immediate |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Consumer takes the record this cycle |
| out_fmt | output | 2 | Format code from bits 31:30 |
| out_opcode | output | 8 | Operation code |
| out_src_a | output | 7 | First source register id |
| out_src_b | output | 7 | Second source register id |
| out_dst_a | output | 7 | First destination register id |
| out_dst_b | output | 7 | Second destination register id |
| out_func | output | 7 | Function code |
| out_imm | output | 32 | Attached immediate |
| out_imm_vld | output | 1 | A trailing immediate was attached |
| out_illegal | output | 1 | Format code 3 was seen |

## Verification
in_ready is combinational and is due in the same cycle as the inputs that set it; a decoded record is due on the outputs one rising edge after the word that completes it is accepted, so a trailed instruction appears one edge after its immediate and never after the instruction word itself. The bench drives inputs shortly after the falling edge, samples 1 ns later, and advances its reference model by exactly the transfers that the coming rising edge will perform. Each sample therefore compares out_valid against whether the model holds a pending record, compares in_ready against the handshake rule, and compares the full record against the head of the model queue whenever a transfer happens at the coming edge.

// File: rtl/fwd_pkg.sv
`timescale 1ns/1ps
package fwd_pkg;

  parameter int unsigned FWD_WORD_W = 32;
  parameter int unsigned FWD_FMT_W  = 2;
  parameter int unsigned FWD_OPC_W  = 8;
  parameter int unsigned FWD_REG_W  = 7;

  // bit positions derived from the widths
  localparam int unsigned FWD_OPC_LSB = FWD_WORD_W - FWD_FMT_W - FWD_OPC_W;
  localparam int unsigned FWD_LO_LSB  = 1;
  localparam int unsigned FWD_MID_LSB = FWD_LO_LSB + FWD_REG_W;
  localparam int unsigned FWD_HI_LSB  = FWD_MID_LSB + FWD_REG_W;

  typedef logic [FWD_REG_W-1:0]  reg_id_t;
  typedef logic [FWD_OPC_W-1:0]  opc_t;
  typedef logic [FWD_WORD_W-1:0] word_t;

  typedef enum logic [FWD_FMT_W-1:0] {
    FMT_TWO_SRC = 2'd0,
    FMT_TWO_DST = 2'd1,
    FMT_FUNC    = 2'd2,
    FMT_BAD     = 2'd3
  } fmt_e;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_TRAIL = 1'b1
  } seq_e;

  // fields that reach the consumer
  typedef struct packed {
    fmt_e    fmt;
    opc_t    opcode;
    reg_id_t src_a;
    reg_id_t src_b;
    reg_id_t dst_a;
    reg_id_t dst_b;
    reg_id_t func;
    logic    illegal;
  } fld_t;

  // fields plus the request for a trailing word
  typedef struct packed {
    fld_t f;
    logic want_trailer;
  } dec_t;

  // complete record held in the output stage
  typedef struct packed {
    fld_t  f;
    word_t imm;
    logic  imm_vld;
  } out_t;

  localparam int unsigned FWD_FLD_W = $bits(fld_t);
  localparam int unsigned FWD_OUT_W = $bits(out_t);

  // one 7-bit register slot starting at a given bit
  function automatic reg_id_t slot_at(input word_t w, input int unsigned lsb);
    return w[lsb +: FWD_REG_W];
  endfunction

  // split an instruction word into its fields
  function automatic dec_t split_word(input word_t w);
    dec_t    d;
    reg_id_t hi;
    reg_id_t mid;
    reg_id_t lo;
    d  = '0;
    hi  = slot_at(w, FWD_HI_LSB);
    mid = slot_at(w, FWD_MID_LSB);
    lo  = slot_at(w, FWD_LO_LSB);
    d.f.fmt = fmt_e'(w[FWD_WORD_W-1 -: FWD_FMT_W]);
    unique case (d.f.fmt)
      FMT_TWO_SRC: begin
        d.f.src_b = hi;
        d.f.src_a = mid;
        d.f.dst_a = lo;
      end
      FMT_TWO_DST: begin
        d.f.src_a = hi;
        d.f.dst_b = mid;
        d.f.dst_a = lo;
      end
      FMT_FUNC: begin
        d.f.func  = hi;
        d.f.src_a = mid;
        d.f.dst_a = lo;
      end
      default: d.f.illegal = 1'b1;
    endcase
    if (!d.f.illegal) begin
      d.f.opcode     = w[FWD_OPC_LSB +: FWD_OPC_W];
      d.want_trailer = w[0];
    end
    return d;
  endfunction

endpackage

// File: rtl/fwd_seq.sv
`timescale 1ns/1ps
module fwd_seq
  import fwd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic in_valid,
  input  logic out_valid_q,
  input  logic out_ready,
  input  logic want_trailer,
  output logic in_ready,
  output logic take_instr,
  output logic take_trailer,
  output logic needs_trail,
  output logic load_out,
  output logic in_trail
);

  seq_e st_q;
  seq_e st_d;
  logic out_free;
  logic accept;

  always_comb begin
    out_free     = !out_valid_q || out_ready;
    in_ready     = !flush && out_free;
    accept       = in_valid && in_ready;
    take_instr   = accept && (st_q == SEQ_IDLE);
    take_trailer = accept && (st_q == SEQ_TRAIL);
    needs_trail  = take_instr && want_trailer;
    load_out     = (take_instr && !want_trailer) || take_trailer;
    in_trail     = (st_q == SEQ_TRAIL);
  end

  always_comb begin
    st_d = st_q;
    if (flush)             st_d = SEQ_IDLE;
    else if (needs_trail)  st_d = SEQ_TRAIL;
    else if (take_trailer) st_d = SEQ_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEQ_IDLE;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/fwd_hold.sv
`timescale 1ns/1ps
module fwd_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (clr) q <= '0;
    else if (en)  q <= d;
  end

endmodule

// File: rtl/fwd_out_stage.sv
`timescale 1ns/1ps
module fwd_out_stage #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          load,
  input  logic          out_ready,
  input  logic [DW-1:0] d,
  output logic          valid_q,
  output logic [DW-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      q       <= '0;
    end else if (flush) begin
      valid_q <= 1'b0;
    end else if (load) begin
      valid_q <= 1'b1;
      q       <= d;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

endmodule

// File: rtl/fetch_word_decoder.sv
`timescale 1ns/1ps
module fetch_word_decoder
  import fwd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [FWD_WORD_W-1:0] in_word,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [FWD_FMT_W-1:0]  out_fmt,
  output logic [FWD_OPC_W-1:0]  out_opcode,
  output logic [FWD_REG_W-1:0]  out_src_a,
  output logic [FWD_REG_W-1:0]  out_src_b,
  output logic [FWD_REG_W-1:0]  out_dst_a,
  output logic [FWD_REG_W-1:0]  out_dst_b,
  output logic [FWD_REG_W-1:0]  out_func,
  output logic [FWD_WORD_W-1:0] out_imm,
  output logic                  out_imm_vld,
  output logic                  out_illegal
);

  // named internal events, also watched by the checker
  logic take_instr_w;
  logic take_trail_w;
  logic needs_trail_w;
  logic load_out_w;
  logic in_trail_w;

  dec_t dec_w;
  fld_t pend_q;
  out_t next_rec;
  out_t rec_q;

  assign dec_w = split_word(in_word);

  fwd_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .in_valid     (in_valid),
    .out_valid_q  (out_valid),
    .out_ready    (out_ready),
    .want_trailer (dec_w.want_trailer),
    .in_ready     (in_ready),
    .take_instr   (take_instr_w),
    .take_trailer (take_trail_w),
    .needs_trail  (needs_trail_w),
    .load_out     (load_out_w),
    .in_trail     (in_trail_w)
  );

  // fields of an instruction waiting for its immediate
  fwd_hold #(.W(FWD_FLD_W)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (flush),
    .en    (needs_trail_w),
    .d     (dec_w.f),
    .q     (pend_q)
  );

  always_comb begin
    if (take_trail_w) begin
      next_rec.f       = pend_q;
      next_rec.imm     = in_word;
      next_rec.imm_vld = 1'b1;
    end else begin
      next_rec.f       = dec_w.f;
      next_rec.imm     = '0;
      next_rec.imm_vld = 1'b0;
    end
  end

  fwd_out_stage #(.DW(FWD_OUT_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .load      (load_out_w),
    .out_ready (out_ready),
    .d         (next_rec),
    .valid_q   (out_valid),
    .q         (rec_q)
  );

  assign out_fmt     = rec_q.f.fmt;
  assign out_opcode  = rec_q.f.opcode;
  assign out_src_a   = rec_q.f.src_a;
  assign out_src_b   = rec_q.f.src_b;
  assign out_dst_a   = rec_q.f.dst_a;
  assign out_dst_b   = rec_q.f.dst_b;
  assign out_func    = rec_q.f.func;
  assign out_imm     = rec_q.imm;
  assign out_imm_vld = rec_q.imm_vld;
  assign out_illegal = rec_q.f.illegal;

  logic unused_take_instr;
  assign unused_take_instr = take_instr_w;

endmodule

// File: rtl/fwd_chk.sv
`timescale 1ns/1ps
module fwd_chk
  import fwd_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  flush,
  input logic                  in_ready,
  input logic [FWD_WORD_W-1:0] in_word,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [FWD_FMT_W-1:0]  out_fmt,
  input logic [FWD_OPC_W-1:0]  out_opcode,
  input logic [FWD_REG_W-1:0]  out_src_a,
  input logic [FWD_REG_W-1:0]  out_src_b,
  input logic [FWD_REG_W-1:0]  out_dst_a,
  input logic [FWD_REG_W-1:0]  out_dst_b,
  input logic [FWD_REG_W-1:0]  out_func,
  input logic [FWD_WORD_W-1:0] out_imm,
  input logic                  out_imm_vld,
  input logic                  out_illegal,
  input logic                  needs_trail,
  input logic                  take_trailer,
  input logic                  load_out,
  input logic                  in_trail
);

  // R9
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !flush |=> out_valid &&
      $stable({out_fmt, out_opcode, out_src_a, out_src_b, out_dst_a,
               out_dst_b, out_func, out_imm, out_imm_vld, out_illegal}));

  // R9
  ready_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);

  // R10
  flush_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !in_ready);

  // R6
  trail_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    needs_trail |=> !out_valid && in_trail);

  // R6
  trail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_trail |-> !out_valid);

  // R6
  trail_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_trailer && !flush |=> out_valid && out_imm_vld && out_imm == $past(in_word));

  // R5
  bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> !out_imm_vld && out_fmt == 2'd3 &&
      out_opcode == '0 && out_src_a == '0 && out_src_b == '0 &&
      out_dst_a == '0 && out_dst_b == '0 && out_func == '0 && out_imm == '0);

  // R7
  plain_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_imm_vld |-> out_imm == '0);

  // R8
  load_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_out && !flush |=> out_valid);

endmodule

bind fetch_word_decoder fwd_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush        (flush),
  .in_ready     (in_ready),
  .in_word      (in_word),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_fmt      (out_fmt),
  .out_opcode   (out_opcode),
  .out_src_a    (out_src_a),
  .out_src_b    (out_src_b),
  .out_dst_a    (out_dst_a),
  .out_dst_b    (out_dst_b),
  .out_func     (out_func),
  .out_imm      (out_imm),
  .out_imm_vld  (out_imm_vld),
  .out_illegal  (out_illegal),
  .needs_trail  (needs_trail_w),
  .take_trailer (take_trail_w),
  .load_out     (load_out_w),
  .in_trail     (in_trail_w)
);

// File: tb/sim_fetch_word_decoder.sv
`timescale 1ns/1ps
module sim_fetch_word_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [1:0]  out_fmt;
  logic [7:0]  out_opcode;
  logic [6:0]  out_src_a, out_src_b, out_dst_a, out_dst_b, out_func;
  logic [31:0] out_imm;
  logic        out_imm_vld, out_illegal;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model state
  logic [78:0] exp_q[$];
  bit          waiting = 0;
  logic [31:0] held_word = '0;

  always #2.5 clk = ~clk;

  fetch_word_decoder u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_fmt(out_fmt), .out_opcode(out_opcode),
    .out_src_a(out_src_a), .out_src_b(out_src_b),
    .out_dst_a(out_dst_a), .out_dst_b(out_dst_b),
    .out_func(out_func), .out_imm(out_imm),
    .out_imm_vld(out_imm_vld), .out_illegal(out_illegal)
  );

  // expected record: {fmt, opcode, src_a, src_b, dst_a, dst_b, func, imm, imm_vld, illegal}
  function automatic logic [78:0] expect_rec(logic [31:0] w, logic [31:0] imm, bit iv);
    logic [1:0] f;
    logic [7:0] op;
    logic [6:0] hi, mid, lo, sa, sb, da, db, fn;
    f   = w >> 30;
    op  = 8'((w >> 22) & 32'hFF);
    hi  = 7'((w >> 15) & 32'h7F);
    mid = 7'((w >> 8) & 32'h7F);
    lo  = 7'((w >> 1) & 32'h7F);
    sa = 0; sb = 0; da = 0; db = 0; fn = 0;
    if (f == 2'd3) return {2'd3, 8'd0, 35'd0, 32'd0, 1'b0, 1'b1};
    if (f == 2'd0) begin sb = hi; sa = mid; da = lo; end
    if (f == 2'd1) begin sa = hi; db = mid; da = lo; end
    if (f == 2'd2) begin fn = hi; sa = mid; da = lo; end
    return {f, op, sa, sb, da, db, fn, iv ? imm : 32'd0, iv, 1'b0};
  endfunction

  function automatic string rec_tag(logic [78:0] r);
    string t;
    case (r[78:77])
      2'd0: t = "R2";
      2'd1: t = "R3";
      2'd2: t = "R4";
      default: t = "R5";
    endcase
    return {t, r[1] ? "/R6" : "/R7"};
  endfunction

  task automatic check(string tag, logic [78:0] act, logic [78:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // one clock cycle: drive, then compare and advance the model
  task automatic cyc(bit v, logic [31:0] w, bit rdy, bit fl);
    bit acc, pop;
    logic [78:0] act;
    @(negedge clk);
    in_valid = v; in_word = w; out_ready = rdy; flush = fl;
    #1;
    // R8: a record is present exactly when the model holds one
    check("R8", {78'd0, out_valid}, {78'd0, exp_q.size() != 0});
    // R9 / R10: ready rule
    check(fl ? "R10" : "R9", {78'd0, in_ready},
          {78'd0, !fl && (!out_valid || rdy)});
    acc = v && in_ready;
    pop = out_valid && rdy;
    act = {out_fmt, out_opcode, out_src_a, out_src_b, out_dst_a, out_dst_b,
           out_func, out_imm, out_imm_vld, out_illegal};
    if (pop && exp_q.size() != 0) begin
      check(rec_tag(exp_q[0]), act, exp_q[0]);
      void'(exp_q.pop_front());
    end
    if (fl) begin
      exp_q.delete();
      waiting = 0;
    end else if (acc) begin
      if (waiting) begin
        exp_q.push_back(expect_rec(held_word, w, 1'b1));
        waiting = 0;
      end else if (w[31:30] != 2'd3 && w[0]) begin
        held_word = w;
        waiting = 1;
      end else begin
        exp_q.push_back(expect_rec(w, 32'd0, 1'b0));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1f3a));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check("R1", {78'd0, out_valid}, 79'd0);
    check("R1", {78'd0, in_ready}, 79'd1);

    // R2 / R3 / R4 plain formats, consumer always ready
    cyc(1, {2'b00, 8'hA5, 7'h11, 7'h22, 7'h33, 1'b0}, 1, 0);
    cyc(1, {2'b01, 8'h3C, 7'h7F, 7'h01, 7'h40, 1'b0}, 1, 0);
    cyc(1, {2'b10, 8'hFF, 7'h55, 7'h2A, 7'h7E, 1'b0}, 1, 0);
    // R5: illegal with bit 0 set, next word is an instruction
    cyc(1, {2'b11, 8'h99, 7'h12, 7'h34, 7'h56, 1'b1}, 1, 0);
    cyc(1, {2'b00, 8'h01, 7'h02, 7'h03, 7'h04, 1'b0}, 1, 0);
    // R6: trailer with idle gap and a stalled consumer
    cyc(1, {2'b10, 8'h77, 7'h05, 7'h06, 7'h07, 1'b1}, 1, 0);
    cyc(0, 32'h0, 1, 0);
    cyc(0, 32'h0, 1, 0);
    cyc(1, 32'hDEADBEEF, 0, 0);
    // R9: held record while out_ready is low, input blocked
    cyc(1, {2'b01, 8'h10, 7'h20, 7'h30, 7'h40, 1'b0}, 0, 0);
    cyc(1, {2'b01, 8'h10, 7'h20, 7'h30, 7'h40, 1'b0}, 0, 0);
    cyc(1, {2'b01, 8'h10, 7'h20, 7'h30, 7'h40, 1'b0}, 1, 0);
    cyc(0, 32'h0, 1, 0);
    // R10: flush while waiting for the trailer
    cyc(1, {2'b00, 8'h44, 7'h01, 7'h01, 7'h01, 1'b1}, 1, 0);
    cyc(1, 32'hCAFEF00D, 1, 1);
    cyc(1, {2'b10, 8'h81, 7'h09, 7'h0A, 7'h0B, 1'b0}, 1, 0);
    // R10: flush drops a stalled record
    cyc(1, {2'b00, 8'h02, 7'h03, 7'h04, 7'h05, 1'b0}, 0, 0);
    cyc(0, 32'h0, 0, 1);
    cyc(0, 32'h0, 1, 0);
    cyc(0, 32'h0, 1, 0);

    // constrained random traffic
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] w;
      w = $urandom;
      w[31:30] = 2'($urandom % 4);
      w[0] = ($urandom % 2) == 0;
      cyc(($urandom % 10) < 6, w, ($urandom % 10) < 7, ($urandom % 40) == 0);
    end
    cyc(0, 32'h0, 1, 0);
    cyc(0, 32'h0, 1, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule